// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block performs the processor state changes that take place when an exception is taken and when a return-from-interrupt executes. On an entry strobe it reads the exception code, the program counter, the current machine-state word, an error code, a restart flag and the exception class. It records a return address and a saved state word in the save pair that belongs to that class. It then builds the handler's machine-state word. Finally it forms the handler address by ORing a vector-table entry with a prefix value.

On a return strobe it reads one of four save pairs. It puts out the restored program counter with the two low bits cleared. It also puts out the restored state word after applying the mask that belongs to that kind of return. A machine check taken while machine checks are disabled does not vector. Instead it stops the block in a checkstop state that only reset clears. The vector table is loaded through a simple write port, and every entry starts out undefined.

Top module: `exc_seq`

## Requirements
- R1: After reset, done, vec_err, checkstop, tgt_pc and new_state are all zero. Every vector-table entry holds all ones, which means undefined.
- R2: An entry strobe that is accepted gives a one-cycle done pulse on the next clock. At that point tgt_pc equals the table entry for ent_code ORed with prefix.
- R3: The handler state keeps only the machine-check-enable bit (bit 12) of ent_state, and all other bits are zero. Bit 0 (little-endian) is set when bit 16 (interrupt little-endian) of ent_state is set.
- R4: The saved state word is ent_state with mask 0x783F0000 cleared, ORed with ent_err. When the parameter EMBEDDED=1, the clearing is skipped.
- R5: The saved return address is ent_pc-4 when ent_restart is 1 and ent_pc when it is 0. On return, the two low bits of the restored address are forced to zero.
- R6: ent_kind selects the save pair: 0 normal, 1 critical, 2 machine check, 3 debug. A debug entry also writes the same values into the critical pair.
- R7: A machine-check entry (kind 2) with bit 12 of ent_state clear sets checkstop and produces no done. From then on, every strobe is ignored until reset. A machine-check entry that is taken clears bit 12 in the handler state.
- R8: An entry whose table word is all ones pulses vec_err instead of done and leaves all save pairs unchanged.
- R9: A return strobe (ret_sel: 0 normal, 1 critical, 2 machine check, 3 debug) gives done on the next clock, with tgt_pc set to the restored address and new_state set to the restored state. The masks are as follows:
  - A normal return masks the state with ~0x783F0000, or applies no mask when EMBEDDED=1.
  - A critical return with ret_legacy=1 masks with ~0xFFFF0000.
  - All other returns apply no mask.
- R10: When the entry and return strobes arrive in the same cycle, the entry is performed and the return is ignored.
- R11: With vt_we high, vt_data is written to table slot vt_addr at the clock edge, and an entry in the following cycle uses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vt_we | input | 1 | Vector-table write enable |
| vt_addr | input | AW | Vector-table slot |
| vt_data | input | W | Vector-table write data |
| prefix | input | W | Value ORed into every handler address |
| ent_valid | input | 1 | Entry strobe |
| ent_code | input | AW | Exception code (table index) |
| ent_kind | input | 2 | Class: 0 normal, 1 critical, 2 machine check, 3 debug |
| ent_pc | input | W | Current program counter |
| ent_state | input | W | Current machine-state word |
| ent_err | input | W | Error bits merged into the saved state |
| ent_restart | input | 1 | Faulting instruction is re-executed |
| ret_valid | input | 1 | Return strobe |
| ret_sel | input | 2 | Save pair to restore from |
| ret_legacy | input | 1 | Legacy mask on a critical return |
| done | output | 1 | Entry or return completed |
| vec_err | output | 1 | Entry hit an undefined vector |
| checkstop | output | 1 | Halted by a disabled machine check |
| tgt_pc | output | W | Handler address or restored address |
| new_state | output | W | Handler state or restored state |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the default parameters (32-bit words, 64 vectors, EMBEDDED=0). The other sets EMBEDDED=1. This lets a single entry show both the cleared and the uncleared saved-state word through a normal return. With 64 vectors, the top slot (code 63) and never-written slots are both within reach of the vector walk. Every save pair, including the debug-to-critical mirror, is observed through the return path.

// File: rtl/exc_seq.sv
module exc_seq #(
  parameter int W = 32,
  parameter int NVEC = 64,
  parameter bit EMBEDDED = 1'b0,
  parameter int ME_BIT = 12,
  parameter int ILE_BIT = 16,
  parameter int LE_BIT = 0,
  parameter logic [W-1:0] SAVE_CLR = 32'h783F0000,
  parameter logic [W-1:0] LEGACY_CLR = 32'hFFFF0000,
  localparam int AW = $clog2(NVEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vt_we,
  input  logic [AW-1:0] vt_addr,
  input  logic [W-1:0]  vt_data,
  input  logic [W-1:0]  prefix,
  input  logic          ent_valid,
  input  logic [AW-1:0] ent_code,
  input  logic [1:0]    ent_kind,
  input  logic [W-1:0]  ent_pc,
  input  logic [W-1:0]  ent_state,
  input  logic [W-1:0]  ent_err,
  input  logic          ent_restart,
  input  logic          ret_valid,
  input  logic [1:0]    ret_sel,
  input  logic          ret_legacy,
  output logic          done,
  output logic          vec_err,
  output logic          checkstop,
  output logic [W-1:0]  tgt_pc,
  output logic [W-1:0]  new_state
);
  localparam logic [1:0] K_NORM = 2'd0;
  localparam logic [1:0] K_CRIT = 2'd1;
  localparam logic [1:0] K_MCHK = 2'd2;
  localparam logic [1:0] K_DBG  = 2'd3;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ME_M = ONE << ME_BIT;
  localparam logic [W-1:0] LE_M = ONE << LE_BIT;
  localparam logic [W-1:0] PC_ALIGN = {{(W-2){1'b1}}, 2'b00};

  logic [W-1:0] vtab  [NVEC];
  logic [W-1:0] sv_pc [4];
  logic [W-1:0] sv_st [4];

  wire [W-1:0] vec       = vtab[ent_code];
  wire         vec_undef = &vec;
  wire         is_mchk   = (ent_kind == K_MCHK);
  wire         stop_now  = is_mchk && !ent_state[ME_BIT];
  wire         go        = ent_valid && !checkstop;
  wire         rgo       = ret_valid && !ent_valid && !checkstop;

  wire [W-1:0] save_pc = ent_restart ? ent_pc - W'(4) : ent_pc;
  wire [W-1:0] save_st = (EMBEDDED ? ent_state : (ent_state & ~SAVE_CLR)) | ent_err;
  wire [W-1:0] hnd_st  = (is_mchk ? '0 : (ent_state & ME_M))
                       | (ent_state[ILE_BIT] ? LE_M : '0);

  logic [W-1:0] rmask;
  always_comb begin
    case (ret_sel)
      K_NORM:  rmask = EMBEDDED ? '1 : ~SAVE_CLR;
      K_CRIT:  rmask = ret_legacy ? ~LEGACY_CLR : '1;
      default: rmask = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NVEC; i++) vtab[i] <= '1;
    end else if (vt_we) begin
      vtab[vt_addr] <= vt_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      vec_err   <= 1'b0;
      checkstop <= 1'b0;
      tgt_pc    <= '0;
      new_state <= '0;
      for (int i = 0; i < 4; i++) begin
        sv_pc[i] <= '0;
        sv_st[i] <= '0;
      end
    end else begin
      done    <= 1'b0;
      vec_err <= 1'b0;
      if (go) begin
        if (stop_now) begin
          checkstop <= 1'b1;
        end else if (vec_undef) begin
          vec_err <= 1'b1;
        end else begin
          done            <= 1'b1;
          tgt_pc          <= vec | prefix;
          new_state       <= hnd_st;
          sv_pc[ent_kind] <= save_pc;
          sv_st[ent_kind] <= save_st;
          if (ent_kind == K_DBG) begin
            sv_pc[K_CRIT] <= save_pc;
            sv_st[K_CRIT] <= save_st;
          end
        end
      end else if (rgo) begin
        done      <= 1'b1;
        tgt_pc    <= sv_pc[ret_sel] & PC_ALIGN;
        new_state <= sv_st[ret_sel] & rmask;
      end
    end
  end
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int W = 32,
  parameter int AW = 6,
  parameter int ME_BIT = 12,
  parameter int LE_BIT = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ent_valid,
  input logic [1:0]    ent_kind,
  input logic [W-1:0]  ent_state,
  input logic          ret_valid,
  input logic          done,
  input logic          vec_err,
  input logic          checkstop,
  input logic [W-1:0]  tgt_pc,
  input logic [W-1:0]  new_state
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] KEEP = (ONE << ME_BIT) | (ONE << LE_BIT);

  assert_done_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ent_valid || ret_valid));

  assert_hnd_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && !checkstop) |=> (!done || ((new_state & ~KEEP) == '0)));

  assert_mchk_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_kind == 2'd2 && !ent_state[ME_BIT] && !checkstop) |=> (checkstop && !done));

  assert_stop_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop |=> (checkstop && !done));

  assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && vec_err));

  assert_ret_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ent_valid && !checkstop) |=> (done && tgt_pc[1:0] == 2'b00));
endmodule

bind exc_seq exc_seq_chk #(.W(W), .AW(AW), .ME_BIT(ME_BIT), .LE_BIT(LE_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_kind(ent_kind),
  .ent_state(ent_state), .ret_valid(ret_valid), .done(done), .vec_err(vec_err),
  .checkstop(checkstop), .tgt_pc(tgt_pc), .new_state(new_state)
);

// File: tb/exc_seq_bench.sv
module exc_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vt_we = 1'b0;
  logic [5:0]  vt_addr = '0;
  logic [31:0] vt_data = '0;
  logic [31:0] prefix = 32'hFFF00000;
  logic        ent_valid = 1'b0;
  logic [5:0]  ent_code = '0;
  logic [1:0]  ent_kind = '0;
  logic [31:0] ent_pc = '0, ent_state = '0, ent_err = '0;
  logic        ent_restart = 1'b0;
  logic        ret_valid = 1'b0;
  logic [1:0]  ret_sel = '0;
  logic        ret_legacy = 1'b0;
  logic        done, vec_err, checkstop, e_done, e_verr, e_cs;
  logic [31:0] tgt_pc, new_state, e_tgt, e_ns;

  int nchk = 0;
  int nerr = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  exc_seq u_exc_seq (
    .clk(clk), .rst_n(rst_n), .vt_we(vt_we), .vt_addr(vt_addr), .vt_data(vt_data),
    .prefix(prefix), .ent_valid(ent_valid), .ent_code(ent_code), .ent_kind(ent_kind),
    .ent_pc(ent_pc), .ent_state(ent_state), .ent_err(ent_err), .ent_restart(ent_restart),
    .ret_valid(ret_valid), .ret_sel(ret_sel), .ret_legacy(ret_legacy),
    .done(done), .vec_err(vec_err), .checkstop(checkstop), .tgt_pc(tgt_pc),
    .new_state(new_state)
  );

  exc_seq #(.EMBEDDED(1'b1)) u_exc_seq_emb (
    .clk(clk), .rst_n(rst_n), .vt_we(vt_we), .vt_addr(vt_addr), .vt_data(vt_data),
    .prefix(prefix), .ent_valid(ent_valid), .ent_code(ent_code), .ent_kind(ent_kind),
    .ent_pc(ent_pc), .ent_state(ent_state), .ent_err(ent_err), .ent_restart(ent_restart),
    .ret_valid(ret_valid), .ret_sel(ret_sel), .ret_legacy(ret_legacy),
    .done(e_done), .vec_err(e_verr), .checkstop(e_cs), .tgt_pc(e_tgt),
    .new_state(e_ns)
  );

  typedef struct packed {
    logic [5:0]  code;
    logic [1:0]  kind;
    logic [31:0] pc;
    logic [31:0] st;
    logic [31:0] err;
    logic        rs;
    logic [1:0]  rsel;
    logic        rleg;
    logic [31:0] x_tgt;
    logic [31:0] x_ns;
    logic [31:0] x_rpc;
    logic [31:0] x_rst;
  } vec_t;

  localparam vec_t TV [6] = '{
    '{6'd5,  2'd0, 32'h00001000, 32'h00011032, 32'h0,        1'b1, 2'd0, 1'b0,
      32'hFFF00700, 32'h00001001, 32'h00000FFC, 32'h00001032},
    '{6'd5,  2'd0, 32'h00002003, 32'h80000002, 32'h00400000, 1'b0, 2'd0, 1'b0,
      32'hFFF00700, 32'h00000000, 32'h00002000, 32'h80400002},
    '{6'd2,  2'd1, 32'h00003000, 32'h00011000, 32'h0,        1'b0, 2'd1, 1'b0,
      32'hFFF00100, 32'h00001001, 32'h00003000, 32'h00001000},
    '{6'd8,  2'd2, 32'h00004008, 32'h78001000, 32'h0,        1'b1, 2'd2, 1'b0,
      32'hFFF00200, 32'h00000000, 32'h00004004, 32'h00001000},
    '{6'd13, 2'd3, 32'h00005000, 32'h00030001, 32'h00000004, 1'b0, 2'd3, 1'b0,
      32'hFFF00D00, 32'h00000001, 32'h00005000, 32'h00000005},
    '{6'd63, 2'd1, 32'h00006000, 32'hFFFFFFFF, 32'h0,        1'b1, 2'd1, 1'b1,
      32'hFFF00F00, 32'h00001001, 32'h00005FFC, 32'h0000FFFF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    vt_we = 1'b1; vt_addr = a; vt_data = d;
    @(negedge clk);
    vt_we = 1'b0;
  endtask

  task automatic enter(input logic [5:0] c, input logic [1:0] k, input logic [31:0] pc,
                       input logic [31:0] st, input logic [31:0] er, input logic rs);
    ent_valid = 1'b1; ent_code = c; ent_kind = k; ent_pc = pc;
    ent_state = st; ent_err = er; ent_restart = rs;
    @(negedge clk);
    ent_valid = 1'b0;
  endtask

  task automatic leave(input logic [1:0] s, input logic lg);
    ret_valid = 1'b1; ret_sel = s; ret_legacy = lg;
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", {31'd0, done}, 32'd0);
    chk("R1 vec_err after reset", {31'd0, vec_err}, 32'd0);
    chk("R1 checkstop after reset", {31'd0, checkstop}, 32'd0);
    chk("R1 tgt_pc after reset", tgt_pc, 32'd0);
    chk("R1 new_state after reset", new_state, 32'd0);

    enter(6'd5, 2'd0, 32'h100, 32'h1000, 32'h0, 1'b0);
    chk("R1 R8 unwritten slot vec_err", {31'd0, vec_err}, 32'd1);
    chk("R8 unwritten slot no done", {31'd0, done}, 32'd0);

    wr(6'd5, 32'h00000700);
    wr(6'd2, 32'h00000100);
    wr(6'd8, 32'h00000200);
    wr(6'd13, 32'h00000D00);
    wr(6'd63, 32'h00000F00);

    for (int i = 0; i < 6; i++) begin
      enter(TV[i].code, TV[i].kind, TV[i].pc, TV[i].st, TV[i].err, TV[i].rs);
      chk($sformatf("R2 R11 entry %0d done", i), {31'd0, done}, 32'd1);
      chk($sformatf("R2 entry %0d handler", i), tgt_pc, TV[i].x_tgt);
      chk($sformatf("R3 R7 entry %0d new state", i), new_state, TV[i].x_ns);
      @(negedge clk);
      chk($sformatf("R2 entry %0d pulse ends", i), {31'd0, done}, 32'd0);
      leave(TV[i].rsel, TV[i].rleg);
      chk($sformatf("R9 return %0d done", i), {31'd0, done}, 32'd1);
      chk($sformatf("R5 R6 R9 return %0d pc", i), tgt_pc, TV[i].x_rpc);
      chk($sformatf("R4 R6 R9 return %0d state", i), new_state, TV[i].x_rst);
    end

    enter(6'd13, 2'd3, 32'h00007000, 32'h00001000, 32'h0, 1'b0);
    leave(2'd1, 1'b0);
    chk("R6 debug mirrored pc", tgt_pc, 32'h00007000);
    chk("R6 debug mirrored state", new_state, 32'h00001000);

    enter(6'd7, 2'd0, 32'h00009000, 32'h00001000, 32'h0, 1'b0);
    chk("R8 undefined vector flag", {31'd0, vec_err}, 32'd1);
    leave(2'd0, 1'b0);
    chk("R8 normal pair pc untouched", tgt_pc, 32'h00002000);
    chk("R8 normal pair state untouched", new_state, 32'h80400002);

    enter(6'd5, 2'd0, 32'h00001000, 32'h00011032, 32'h0, 1'b0);
    leave(2'd0, 1'b0);
    chk("R4 default saved state cleared", new_state, 32'h00001032);
    chk("R4 embedded saved state kept", e_ns, 32'h00011032);
    chk("R9 embedded normal return pc", e_tgt, 32'h00001000);

    ret_valid = 1'b1; ret_sel = 2'd0; ret_legacy = 1'b0;
    enter(6'd5, 2'd0, 32'h00008000, 32'h0, 32'h0, 1'b0);
    ret_valid = 1'b0;
    chk("R10 entry wins done", {31'd0, done}, 32'd1);
    chk("R10 entry wins address", tgt_pc, 32'hFFF00700);
    chk("R10 entry wins state", new_state, 32'd0);

    enter(6'd8, 2'd2, 32'h0000A000, 32'h00000000, 32'h0, 1'b0);
    chk("R7 checkstop set", {31'd0, checkstop}, 32'd1);
    chk("R7 no done on checkstop", {31'd0, done}, 32'd0);
    enter(6'd5, 2'd0, 32'h0000B000, 32'h00001000, 32'h0, 1'b0);
    chk("R7 entry ignored in checkstop", {31'd0, done}, 32'd0);
    chk("R7 handler output held", tgt_pc, 32'hFFF00700);
    leave(2'd0, 1'b0);
    chk("R7 return ignored in checkstop", {31'd0, done}, 32'd0);
    chk("R7 checkstop sticky", {31'd0, checkstop}, 32'd1);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset clears checkstop", {31'd0, checkstop}, 32'd0);
    enter(6'd5, 2'd0, 32'h100, 32'h1000, 32'h0, 1'b0);
    chk("R1 table reset to undefined", {31'd0, vec_err}, 32'd1);

    finish_run();
  end
endmodule